// File: doc/BRIEF.md
# Radix-4 Booth Multiplier with Logarithmic Partial-Product Shifters

This block multiplies two W-bit operands (16 by default) in a single combinational pass and returns a 2W-bit product. A mode input selects how the operands are read. In one mode both are unsigned. In the other both are two's complement. The same datapath serves both modes.

The multiplier operand is recoded into radix-4 Booth digits, which roughly halves the number of partial products. Each digit selects zero, plus or minus the multiplicand, or plus or minus twice the multiplicand. Each selected term is then moved to its weight by its own multiplexer-layer logarithmic left shifter, rather than by fixed wiring. The terms are extended to the full product width, and a balanced adder tree sums them. A single correction word carries the +1 carries of all negated digits. The block has no clock and no state, and is meant to sit inside a larger registered datapath.

Top module: `booth_shift_mult`

## Requirements
- R1: With `signed_mode` = 0, `product` equals the unsigned product of `mcand` and `mplier`, for every operand pair.
- R2: With `signed_mode` = 1, `product` equals the two's complement product of `mcand` and `mplier`, written as a 2W-bit two's complement value.
- R3: Booth group k is taken from multiplier bits 2k+1, 2k and 2k-1, with a 0 below bit 0. The codes map as follows: 000 and 111 give 0; 001 and 010 give +1x; 011 gives +2x; 100 gives -2x; 101 and 110 give -1x. A digit never selects 1x and 2x at the same time.
- R4: There are W/2+1 groups. Above its top bit, the multiplier is extended with two copies of its sign bit in signed mode and with two zeros in unsigned mode. As a result, the extra top group is always zero in signed mode.
- R5: A negative digit is formed by bitwise inversion of the extended term, plus a 1 at the term's lowest weight 2k. The term plus its correction equals the negated shifted magnitude.
- R6: A x2 digit doubles the extended multiplicand by a one-bit left shift, applied before the positional shift.
- R7: Each term is positioned by log2(2W) layers of 2:1 multiplexers. Layer i shifts left by 2^(i-1) when bit i-1 of the amount is 1, and passes its input unchanged otherwise. The result equals the input shifted left by the amount, with zero fill.
- R8: Before summation, the multiplicand is sign-extended (signed mode) or zero-extended (unsigned mode) to 2W bits. For example, in signed mode 0x8000 times 0x8000 gives 0x40000000, and 0xFFFF times 0xFFFF gives 1.
- R9: Corner operands 0, 1, all ones, 0x8000 and 0x7FFF give the arithmetically correct product in both modes. Any operand of 0 gives a product of 0.
- R10: When both operands have their top bit clear, the product is the same in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand | input | W | Multiplicand |
| mplier | input | W | Multiplier, Booth-recoded |
| signed_mode | input | 1 | 1: two's complement operands; 0: unsigned operands |
| product | output | 2W | Product |

## Verification
The assertions sit in combinational blocks, so they take for granted that the inputs are settled, two-state values whenever the logic is evaluated. The bench meets this by changing the operands only on the clock's rising edge and reading results half a period later. The internal assertions also assume that W is even, so that the groups tile the multiplier exactly. The stimulus keeps to even widths: a 4-bit copy is swept over every operand pair in both modes, and the 16-bit instance is driven with corner values and pseudo-random pairs.

// File: rtl/booth_pkg.sv
// Shared types for the Booth multiplier.
// Assumes: nothing beyond a two-state encoding of the digit fields.
package booth_pkg;

    // One radix-4 digit: sign, and a one-hot choice of |1x| or |2x| (none = zero).
    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } booth_digit_t;

endpackage

// File: rtl/booth_recoder.sv
// Recodes a W-bit multiplier into W/2+1 radix-4 Booth digits.
// Assumes: W is even. The top group sees the multiplier extended by two
// bits: copies of its sign in signed mode, zeros in unsigned mode.
module booth_recoder
    import booth_pkg::*;
#(
    parameter int W = 16,
    localparam int NG = W / 2 + 1
) (
    input  logic [W-1:0]                mplier,
    input  logic                        signed_mode,
    output booth_digit_t [NG-1:0]       digits
);

    localparam int XW = W + 3;

    logic [XW-1:0] ext;

    // Purpose: build {2 extension bits, multiplier, implicit zero}.
    always_comb begin
        logic top;
        top = signed_mode & mplier[W-1];
        ext = {top, top, mplier, 1'b0};
    end

    for (genvar k = 0; k < NG; k++) begin : g_grp
        logic [2:0] trip;
        assign trip = ext[2*k +: 3];

        // Purpose: map one overlapping triplet to a digit.
        always_comb begin
            digits[k].neg = trip[2] & ~(trip[1] & trip[0]);
            digits[k].one = trip[1] ^ trip[0];
            digits[k].two = (trip[2] & ~trip[1] & ~trip[0]) |
                            (~trip[2] & trip[1] & trip[0]);
        end

        // Purpose: guard the digit encoding (R3).
        always_comb begin
            p_digit_legal_r3: assert (!(digits[k].one && digits[k].two))
                else $error("R3: digit %0d selects both 1x and 2x", k);
            p_zero_not_neg_r3: assert (digits[k].one || digits[k].two || !digits[k].neg)
                else $error("R3: zero digit %0d carries a sign", k);
        end
    end

    // Purpose: in signed mode the extra top group must contribute nothing (R4).
    always_comb begin
        if (signed_mode) begin
            p_top_zero_r4: assert (!digits[NG-1].one && !digits[NG-1].two)
                else $error("R4: top group nonzero in signed mode");
        end
    end

endmodule

// File: rtl/log_shifter.sv
// Left shifter built from SW layers of DW 2:1 multiplexers with zero fill.
// Assumes: amt < DW. Layer i moves the word by 2**i when amt[i] is set.
module log_shifter #(
    parameter int DW = 32,
    localparam int SW = $clog2(DW)
) (
    input  logic [DW-1:0] din,
    input  logic [SW-1:0] amt,
    output logic [DW-1:0] dout
);

    logic [SW:0][DW-1:0] stage;

    assign stage[0] = din;

    for (genvar i = 0; i < SW; i++) begin : g_layer
        // Purpose: one multiplexer layer, shift by 2**i or pass through.
        assign stage[i+1] = amt[i] ? (stage[i] << (1 << i)) : stage[i];
    end

    assign dout = stage[SW];

    // Purpose: the layered result must equal a direct shift (R7).
    always_comb begin
        p_shift_exact_r7: assert (dout == (din << amt))
            else $error("R7: layered shift mismatch");
    end

endmodule

// File: rtl/booth_pp_gen.sv
// Forms the partial product for Booth group K. The multiplicand is extended
// to PW bits, doubled, inverted and positioned by a log shifter. For a
// negative digit, the +1 needed at weight 2K is returned separately.
// Assumes: digit fields obey the recoder encoding.
module booth_pp_gen
    import booth_pkg::*;
#(
    parameter int W = 16,
    parameter int K = 0,
    localparam int PW = 2 * W,
    localparam int SW = $clog2(PW)
) (
    input  logic [W-1:0]  mcand,
    input  logic          signed_mode,
    input  booth_digit_t  dig,
    output logic [PW-1:0] pp,
    output logic [PW-1:0] corr
);

    localparam logic [SW-1:0] AMT = SW'(2 * K);

    logic [PW-1:0] ext, mag, sel, inv;

    // Purpose: sign- or zero-extend, double, select and invert the term.
    always_comb begin
        ext  = signed_mode ? {{W{mcand[W-1]}}, mcand} : {{W{1'b0}}, mcand};
        mag  = dig.two ? (ext << 1) : ext;
        sel  = (dig.one | dig.two) ? mag : '0;
        inv  = dig.neg ? ~sel : sel;
        corr = dig.neg ? (PW'(1) << AMT) : '0;
    end

    log_shifter #(.DW(PW)) u_shift (
        .din  (inv),
        .amt  (AMT),
        .dout (pp)
    );

    // Purpose: check the zero digit and the negation identity (R3, R5).
    always_comb begin
        if (!dig.one && !dig.two) begin
            p_zero_digit_r3: assert (pp == '0 && corr == '0)
                else $error("R3: zero digit gave nonzero term");
        end
        if (dig.neg) begin
            p_neg_identity_r5: assert (PW'(pp + corr) == PW'('0 - (mag << AMT)))
                else $error("R5: negated term wrong");
        end
    end

endmodule

// File: rtl/adder_tree.sv
// Balanced binary tree of ordinary adders over NT terms, modulo 2**PW.
// Assumes: NT >= 2. Unused leaves are tied to zero.
module adder_tree #(
    parameter int NT = 10,
    parameter int PW = 32,
    localparam int LV  = $clog2(NT),
    localparam int PAD = 1 << LV
) (
    input  logic [NT-1:0][PW-1:0] terms,
    output logic [PW-1:0]         sum
);

    logic [2*PAD-2:0][PW-1:0] node;

    for (genvar i = 0; i < PAD; i++) begin : g_leaf
        if (i < NT) begin : g_used
            assign node[PAD-1+i] = terms[i];
        end else begin : g_pad
            assign node[PAD-1+i] = '0;
        end
    end

    for (genvar n = 0; n < PAD - 1; n++) begin : g_node
        // Purpose: one adder joining two children.
        assign node[n] = node[2*n+1] + node[2*n+2];
    end

    assign sum = node[0];

endmodule

// File: rtl/booth_shift_mult.sv
// Top: combinational W x W multiplier, signed or unsigned by signed_mode.
// Recodes, generates shifted partial products, and sums them together
// with one word that gathers every negation carry.
// Assumes: W even; inputs settled when read. No clock, so no reset.
module booth_shift_mult
    import booth_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    input  logic           signed_mode,
    output logic [2*W-1:0] product
);

    localparam int NG = W / 2 + 1;
    localparam int PW = 2 * W;
    localparam int NT = NG + 1;

    booth_digit_t [NG-1:0]  digits;
    logic [NG-1:0][PW-1:0]  pps;
    logic [NG-1:0][PW-1:0]  corrs;
    logic [PW-1:0]          corr_all;
    logic [NT-1:0][PW-1:0]  terms;

    booth_recoder #(.W(W)) u_rec (
        .mplier      (mplier),
        .signed_mode (signed_mode),
        .digits      (digits)
    );

    for (genvar k = 0; k < NG; k++) begin : g_pp
        booth_pp_gen #(.W(W), .K(k)) u_pp (
            .mcand       (mcand),
            .signed_mode (signed_mode),
            .dig         (digits[k]),
            .pp          (pps[k]),
            .corr        (corrs[k])
        );
        assign terms[k] = pps[k];
    end

    // Purpose: merge the disjoint +1 corrections into one word.
    always_comb begin
        corr_all = '0;
        for (int k = 0; k < NG; k++) begin
            corr_all = corr_all | corrs[k];
        end
    end

    assign terms[NT-1] = corr_all;

    adder_tree #(.NT(NT), .PW(PW)) u_tree (
        .terms (terms),
        .sum   (product)
    );

    // Purpose: zero operands and a unit multiplicand give trivial results (R9, R1).
    always_comb begin
        if (mcand == '0 || mplier == '0) begin
            p_zero_operand_r9: assert (product == '0)
                else $error("R9: zero operand gave nonzero product");
        end
        if (!signed_mode && mcand == W'(1)) begin
            p_unit_unsigned_r1: assert (product == {{W{1'b0}}, mplier})
                else $error("R1: 1 x b differs from b");
        end
    end

endmodule

// File: tb/tb_booth_shift_mult.sv
module tb_booth_shift_mult;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [15:0] a, b;
    logic        sm;
    logic [31:0] prod;

    logic [3:0]  a4, b4;
    logic        sm4;
    logic [7:0]  prod4;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    booth_shift_mult #(.W(16)) dut (
        .mcand(a), .mplier(b), .signed_mode(sm), .product(prod)
    );

    booth_shift_mult #(.W(4)) dut_w4 (
        .mcand(a4), .mplier(b4), .signed_mode(sm4), .product(prod4)
    );

    function automatic logic [31:0] ref16(logic [15:0] x, logic [15:0] y, logic s);
        longint xe, ye;
        xe = s ? longint'($signed(x)) : longint'(x);
        ye = s ? longint'($signed(y)) : longint'(y);
        return 32'(xe * ye);
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: a=%h b=%h mode=%0b got %h expected %h", req, a, b, sm, got, exp);
        end
    endtask

    task automatic apply16(logic [15:0] x, logic [15:0] y, logic s, string req);
        @(posedge clk);
        a = x; b = y; sm = s;
        @(negedge clk);
        chk(req, prod, ref16(x, y, s));
    endtask

    initial begin
        a = '0; b = '0; sm = 1'b0;
        a4 = '0; b4 = '0; sm4 = 1'b0;
        @(negedge clk);
        chk("R9 start with zero operands", prod, 32'h0);

        // R8 and R9: corner operands in both modes
        for (int s = 0; s < 2; s++) begin
            logic [15:0] corner [5];
            corner[0] = 16'h0000; corner[1] = 16'h0001; corner[2] = 16'hFFFF;
            corner[3] = 16'h8000; corner[4] = 16'h7FFF;
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    apply16(corner[i], corner[j], s[0], "R9 corner");
        end
        apply16(16'h8000, 16'h8000, 1'b1, "R8 most negative squared");
        chk("R8 value 0x40000000", prod, 32'h4000_0000);
        apply16(16'hFFFF, 16'hFFFF, 1'b1, "R8 minus one squared");
        chk("R8 value 1", prod, 32'h0000_0001);
        apply16(16'hFFFF, 16'hFFFF, 1'b0, "R4 unsigned top group");
        chk("R4 value 0xFFFE0001", prod, 32'hFFFE_0001);

        // R3, R5, R6: multipliers whose low groups hit each digit code
        for (int c = 0; c < 8; c++) begin
            apply16(16'h1234, 16'(c), 1'b1, "R3 single group code");
            apply16(16'hB5C3, 16'(c << 5), 1'b0, "R5 negative digits");
            apply16(16'h4321, 16'(c << 13), 1'b1, "R6 doubled digits");
        end

        // R7: single-bit multipliers exercise every positional shift
        for (int k = 0; k < 16; k++) begin
            apply16(16'h0001, 16'(1 << k), 1'b0, "R7 shift position");
            apply16(16'hFFFF, 16'(1 << k), 1'b1, "R7 negative shifted");
        end

        // R1, R2, R10: pseudo-random pairs
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] x, y;
            x = 16'($urandom);
            y = 16'($urandom);
            apply16(x, y, 1'b0, "R1 unsigned random");
            apply16(x, y, 1'b1, "R2 signed random");
            x[15] = 1'b0; y[15] = 1'b0;
            apply16(x, y, 1'b0, "R10 mode agree unsigned");
            begin
                logic [31:0] p_u;
                p_u = prod;
                apply16(x, y, 1'b1, "R10 mode agree signed");
                chk("R10 same product in both modes", prod, p_u);
            end
        end

        // R1, R2: exhaustive sweep of the 4-bit copy
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 16; i++)
                for (int j = 0; j < 16; j++) begin
                    int xi, yj;
                    logic [7:0] e;
                    @(posedge clk);
                    a4 = 4'(i); b4 = 4'(j); sm4 = s[0];
                    xi = (s == 1 && i >= 8) ? i - 16 : i;
                    yj = (s == 1 && j >= 8) ? j - 16 : j;
                    e = 8'(xi * yj);
                    @(negedge clk);
                    n_cmp++;
                    if (prod4 !== e) begin
                        n_bad++;
                        $display("FAIL %s: w4 a=%h b=%h got %h expected %h",
                                 (s == 1) ? "R2" : "R1", a4, b4, prod4, e);
                    end
                end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule